// File: doc/BRIEF.md
# Load/Store Queue with Store-to-Load Forwarding

This block tracks every in-flight memory operation of an out-of-order core in program order and decides, each cycle, which load may go to memory. Operations are allocated at dispatch and receive a queue tag. Their effective addresses arrive later from an address-generation path outside the queue. Store data arrives on a separate writeback port. The queue is a circular buffer with head and tail pointers, and `DEPTH` must be a power of two.

Each slot runs a small state machine. FREE moves to NOADDR on allocation (transition ALLOC). NOADDR moves to HASADDR when the address is written back (transition AGEN). A store that already holds its data goes straight to DONE instead (transition AGEN_FULL). From HASADDR, a store moves to DONE when its data arrives (transition SDATA), and a load moves to DONE when it is performed (transition PERFORM). DONE returns to FREE when the entry is committed at the head (transition RETIRE). A flush sends any slot to FREE (transition KILL).

In each cycle at most one load is performed. It is either sent to the data cache, or it takes its value from the youngest older store with the same address. A store writes the data cache only when it retires from the head. A misprediction flush keeps the entries up to and including a given tag and discards every younger one.

Top module: `ldst_queue`

## Requirements
- R1: After reset the queue is empty. `alloc_ready` is 1, `alloc_tag` is 0, and `ld_mem_valid`, `ld_fwd_valid` and `st_wr_valid` are all 0.
- R2: An accepted allocation gets tag `tail`, and tags increase by one modulo `DEPTH` in program order. `alloc_ready` is 0 exactly when `DEPTH` entries are held. An allocation request while `alloc_ready` is 0 is dropped.
- R3: A load can be performed only after its address has been written back. At most one load is performed per cycle. The one chosen is the oldest load that is able to proceed. A performed load is never performed again.
- R4: A load with a known address does not proceed while any older store in the queue still lacks its address.
- R5: If one or more older stores have the load's exact address, the load is performed on the forward port (`ld_fwd_valid`, `ld_fwd_tag`, `ld_fwd_data`). It takes the data of the youngest such store, and nothing is sent to the cache port.
- R6: If the youngest matching older store has not yet received its data, the load stalls.
- R7: A load with no unknown-address older store and no match is sent to the cache port (`ld_mem_valid`, `ld_mem_tag`, `ld_mem_addr`).
- R8: `commit_valid` retires the head entry only if that entry is complete: a load that has been performed, or a store with both address and data. Otherwise it is ignored. Retiring a store raises `st_wr_valid` in the same cycle, with the store's address and data. Retiring a load produces no write.
- R9: An allocation and a commit in the same cycle both take effect.
- R10: `flush_valid` with `flush_tag` discards all entries younger than `flush_tag`, so the next allocation gets tag `flush_tag+1`. An allocation request in a flush cycle is ignored, and no load is performed in a flush cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate one entry at the tail |
| alloc_store | input | 1 | 1 = store, 0 = load |
| alloc_ready | output | 1 | Queue can accept an allocation |
| alloc_tag | output | TW | Tag given to the allocation |
| agen_valid | input | 1 | Effective address writeback |
| agen_tag | input | TW | Entry receiving the address |
| agen_addr | input | AW | Effective address |
| sdat_valid | input | 1 | Store data writeback |
| sdat_tag | input | TW | Store entry receiving the data |
| sdat_value | input | DW | Store data |
| ld_mem_valid | output | 1 | Load sent to the data cache |
| ld_mem_tag | output | TW | Tag of that load |
| ld_mem_addr | output | AW | Address of that load |
| ld_fwd_valid | output | 1 | Load satisfied by forwarding |
| ld_fwd_tag | output | TW | Tag of the forwarded load |
| ld_fwd_data | output | DW | Forwarded store data |
| commit_valid | input | 1 | Retire the head entry |
| st_wr_valid | output | 1 | Store write to the data cache |
| st_wr_addr | output | AW | Store write address |
| st_wr_data | output | DW | Store write data |
| flush_valid | input | 1 | Discard entries younger than flush_tag |
| flush_tag | input | TW | Youngest entry to keep |

## Verification
The load outputs are combinational from the slot states held at the start of the cycle. A load therefore appears one cycle after the edge that captured its address, and the flush of that same cycle can still mask it. The store write and `alloc_ready`/`alloc_tag` reflect the inputs and state of the current cycle. Slot updates from writebacks, commits and flushes become visible one edge later. The bench drives inputs on the falling edge and samples 1 ns after it. It compares each output against a program-order model that it updates after every rising edge.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
    typedef enum logic [1:0] {
        S_FREE    = 2'd0,
        S_NOADDR  = 2'd1,
        S_HASADDR = 2'd2,
        S_DONE    = 2'd3
    } slot_state_e;
endpackage

// File: rtl/lsq_slot.sv
module lsq_slot import lsq_pkg::*; #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_hit,
    input  logic          alloc_store,
    input  logic          addr_hit,
    input  logic [AW-1:0] addr_in,
    input  logic          data_hit,
    input  logic [DW-1:0] data_in,
    input  logic          perform_hit,
    input  logic          release_hit,
    input  logic          kill_hit,
    output slot_state_e   state_o,
    output logic          is_store_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          data_ok_o
);
    slot_state_e   state_q, state_d;
    logic          is_st_q, dok_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_FREE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FREE:    if (alloc_hit) state_d = S_NOADDR;
            S_NOADDR:  if (addr_hit)
                           state_d = (is_st_q && (dok_q || data_hit)) ? S_DONE : S_HASADDR;
            S_HASADDR: if (is_st_q ? data_hit : perform_hit) state_d = S_DONE;
            S_DONE:    if (release_hit) state_d = S_FREE;
            default:   state_d = S_FREE;
        endcase
        if (kill_hit) state_d = S_FREE;
    end

    // payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_st_q <= 1'b0;
            dok_q   <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            if (alloc_hit) begin
                is_st_q <= alloc_store;
                dok_q   <= 1'b0;
            end else if (data_hit) begin
                data_q <= data_in;
                dok_q  <= 1'b1;
            end
            if (addr_hit) addr_q <= addr_in;
        end
    end

    // outputs
    always_comb begin
        state_o    = state_q;
        is_store_o = is_st_q;
        addr_o     = addr_q;
        data_o     = data_q;
        data_ok_o  = dok_q;
    end

    assert_perform_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        perform_hit |-> (state_q == S_HASADDR && !is_st_q));

    assert_store_done_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE && is_st_q) |-> dok_q);

    assert_free_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FREE && !alloc_hit) |=> state_q == S_FREE);
endmodule

// File: rtl/lsq_ptrs.sv
module lsq_ptrs #(
    parameter int DEPTH = 8,
    localparam int TW = $clog2(DEPTH),
    localparam int CW = TW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_fire,
    input  logic          commit_fire,
    input  logic          flush_valid,
    input  logic [TW-1:0] flush_age,
    output logic [TW-1:0] head_idx,
    output logic [TW-1:0] tail_idx,
    output logic [CW-1:0] count_o
);
    logic [CW-1:0] head_q, tail_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (commit_fire) head_q <= head_q + CW'(1);
            if (flush_valid)     tail_q <= head_q + {1'b0, flush_age} + CW'(1);
            else if (alloc_fire) tail_q <= tail_q + CW'(1);
        end
    end

    assign head_idx = head_q[TW-1:0];
    assign tail_idx = tail_q[TW-1:0];
    assign count_o  = tail_q - head_q;

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(DEPTH));

    assert_alloc_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && commit_fire && !flush_valid) |=> count_o == $past(count_o));

    assert_flush_shrinks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> count_o <= $past(count_o));
endmodule

// File: rtl/lsq_pick.sv
module lsq_pick import lsq_pkg::*; #(
    parameter int DEPTH = 8,
    parameter int AW = 16,
    parameter int DW = 16,
    localparam int TW = $clog2(DEPTH),
    localparam int CW = TW + 1
) (
    input  slot_state_e   st_i    [DEPTH],
    input  logic          is_st_i [DEPTH],
    input  logic [AW-1:0] addr_i  [DEPTH],
    input  logic [DW-1:0] data_i  [DEPTH],
    input  logic          dok_i   [DEPTH],
    input  logic [TW-1:0] head_idx,
    input  logic [CW-1:0] count,
    output logic          pick_valid,
    output logic          pick_fwd,
    output logic [TW-1:0] pick_idx,
    output logic [AW-1:0] pick_addr,
    output logic [DW-1:0] pick_data
);
    logic [TW-1:0] p, q;
    logic          blk, hit, hit_rdy;
    logic [DW-1:0] hit_data;

    // age-ordered scan: oldest load that can proceed wins
    always_comb begin
        pick_valid = 1'b0;
        pick_fwd   = 1'b0;
        pick_idx   = '0;
        pick_addr  = '0;
        pick_data  = '0;
        p = '0; q = '0;
        blk = 1'b0; hit = 1'b0; hit_rdy = 1'b0; hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            p = head_idx + TW'(k);
            if (!pick_valid && (CW'(k) < count) && st_i[p] == S_HASADDR && !is_st_i[p]) begin
                blk = 1'b0; hit = 1'b0; hit_rdy = 1'b0; hit_data = '0;
                for (int j = 0; j < DEPTH; j++) begin
                    q = head_idx + TW'(j);
                    if (j < k && is_st_i[q]) begin
                        if (st_i[q] == S_NOADDR) begin
                            blk = 1'b1;
                        end else if (addr_i[q] == addr_i[p]) begin
                            hit      = 1'b1;
                            hit_rdy  = dok_i[q];
                            hit_data = data_i[q];
                        end
                    end
                end
                if (!blk && !(hit && !hit_rdy)) begin
                    pick_valid = 1'b1;
                    pick_fwd   = hit;
                    pick_idx   = p;
                    pick_addr  = addr_i[p];
                    pick_data  = hit_data;
                end
            end
        end
    end
endmodule

// File: rtl/ldst_queue.sv
module ldst_queue import lsq_pkg::*; #(
    parameter int DEPTH = 8,
    parameter int AW = 16,
    parameter int DW = 16,
    localparam int TW = $clog2(DEPTH),
    localparam int CW = TW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic          alloc_store,
    output logic          alloc_ready,
    output logic [TW-1:0] alloc_tag,
    input  logic          agen_valid,
    input  logic [TW-1:0] agen_tag,
    input  logic [AW-1:0] agen_addr,
    input  logic          sdat_valid,
    input  logic [TW-1:0] sdat_tag,
    input  logic [DW-1:0] sdat_value,
    output logic          ld_mem_valid,
    output logic [TW-1:0] ld_mem_tag,
    output logic [AW-1:0] ld_mem_addr,
    output logic          ld_fwd_valid,
    output logic [TW-1:0] ld_fwd_tag,
    output logic [DW-1:0] ld_fwd_data,
    input  logic          commit_valid,
    output logic          st_wr_valid,
    output logic [AW-1:0] st_wr_addr,
    output logic [DW-1:0] st_wr_data,
    input  logic          flush_valid,
    input  logic [TW-1:0] flush_tag
);
    slot_state_e   st_w    [DEPTH];
    logic          is_st_w [DEPTH];
    logic [AW-1:0] addr_w  [DEPTH];
    logic [DW-1:0] data_w  [DEPTH];
    logic          dok_w   [DEPTH];

    logic [TW-1:0] head_idx, tail_idx, flush_age, pick_idx;
    logic [CW-1:0] count;
    logic          alloc_fire, commit_fire, pick_valid, pick_fwd, pick_ok;
    logic [AW-1:0] pick_addr;
    logic [DW-1:0] pick_data;

    assign alloc_ready = (count != CW'(DEPTH));
    assign alloc_fire  = alloc_valid && alloc_ready && !flush_valid;
    assign alloc_tag   = tail_idx;
    assign commit_fire = commit_valid && (count != '0) && (st_w[head_idx] == S_DONE);
    assign flush_age   = flush_tag - head_idx;
    assign pick_ok     = pick_valid && !flush_valid;

    lsq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_fire  (alloc_fire),
        .commit_fire (commit_fire),
        .flush_valid (flush_valid),
        .flush_age   (flush_age),
        .head_idx    (head_idx),
        .tail_idx    (tail_idx),
        .count_o     (count)
    );

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic [TW-1:0] age;
        logic          kill_s, alloc_s, perf_s, rel_s, agen_s, sdat_s;
        assign age     = TW'(s) - head_idx;
        assign kill_s  = flush_valid && ({1'b0, age} < count) && (age > flush_age);
        assign alloc_s = alloc_fire && (tail_idx == TW'(s));
        assign perf_s  = pick_ok && (pick_idx == TW'(s));
        assign rel_s   = commit_fire && (head_idx == TW'(s));
        assign agen_s  = agen_valid && (agen_tag == TW'(s));
        assign sdat_s  = sdat_valid && (sdat_tag == TW'(s));

        lsq_slot #(.AW(AW), .DW(DW)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc_hit   (alloc_s),
            .alloc_store (alloc_store),
            .addr_hit    (agen_s),
            .addr_in     (agen_addr),
            .data_hit    (sdat_s),
            .data_in     (sdat_value),
            .perform_hit (perf_s),
            .release_hit (rel_s),
            .kill_hit    (kill_s),
            .state_o     (st_w[s]),
            .is_store_o  (is_st_w[s]),
            .addr_o      (addr_w[s]),
            .data_o      (data_w[s]),
            .data_ok_o   (dok_w[s])
        );
    end

    lsq_pick #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_pick (
        .st_i       (st_w),
        .is_st_i    (is_st_w),
        .addr_i     (addr_w),
        .data_i     (data_w),
        .dok_i      (dok_w),
        .head_idx   (head_idx),
        .count      (count),
        .pick_valid (pick_valid),
        .pick_fwd   (pick_fwd),
        .pick_idx   (pick_idx),
        .pick_addr  (pick_addr),
        .pick_data  (pick_data)
    );

    always_comb begin
        ld_mem_valid = pick_ok && !pick_fwd;
        ld_mem_tag   = pick_idx;
        ld_mem_addr  = pick_addr;
        ld_fwd_valid = pick_ok && pick_fwd;
        ld_fwd_tag   = pick_idx;
        ld_fwd_data  = pick_data;
        st_wr_valid  = commit_fire && is_st_w[head_idx];
        st_wr_addr   = addr_w[head_idx];
        st_wr_data   = data_w[head_idx];
    end

    assert_st_write_advances_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_valid |=> head_idx == $past(head_idx) + TW'(1));

    assert_one_load_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_mem_valid && ld_fwd_valid));
endmodule

// File: tb/ldst_queue_tb.sv
`timescale 1ns/1ps
module ldst_queue_tb;
    localparam int D = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        a_v = 0, a_st = 0, g_v = 0, d_v = 0, c_v = 0, f_v = 0;
    logic [2:0]  g_t = 0, d_t = 0, f_t = 0;
    logic [15:0] g_a = 0, d_d = 0;

    logic        alloc_ready, ld_mem_valid, ld_fwd_valid, st_wr_valid;
    logic [2:0]  alloc_tag, ld_mem_tag, ld_fwd_tag;
    logic [15:0] ld_mem_addr, ld_fwd_data, st_wr_addr, st_wr_data;

    ldst_queue u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(a_v), .alloc_store(a_st), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .agen_valid(g_v), .agen_tag(g_t), .agen_addr(g_a),
        .sdat_valid(d_v), .sdat_tag(d_t), .sdat_value(d_d),
        .ld_mem_valid(ld_mem_valid), .ld_mem_tag(ld_mem_tag), .ld_mem_addr(ld_mem_addr),
        .ld_fwd_valid(ld_fwd_valid), .ld_fwd_tag(ld_fwd_tag), .ld_fwd_data(ld_fwd_data),
        .commit_valid(c_v),
        .st_wr_valid(st_wr_valid), .st_wr_addr(st_wr_addr), .st_wr_data(st_wr_data),
        .flush_valid(f_v), .flush_tag(f_t)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    bit          m_st [D], m_ak [D], m_dk [D], m_dn [D];
    logic [15:0] m_addr [D], m_data [D];
    int          m_head = 0, m_cnt = 0;

    // sampled outputs of the last tick
    logic        s_rdy, s_mv, s_fv, s_sv;
    logic [2:0]  s_tag, s_mt, s_ft;
    logic [15:0] s_ma, s_fd, s_sa, s_sd;

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit complete(int p);
        return m_st[p] ? (m_ak[p] && m_dk[p]) : m_dn[p];
    endfunction

    function automatic void exp_pick(output bit v, output bit fwd, output int idx, output logic [15:0] val);
        v = 0; fwd = 0; idx = 0; val = 0;
        for (int k = 0; k < m_cnt; k++) begin
            int p = (m_head + k) % D;
            if (!v && !m_st[p] && m_ak[p] && !m_dn[p]) begin
                bit blk = 0, hit = 0, hr = 0;
                logic [15:0] hd = 0;
                for (int j = 0; j < k; j++) begin
                    int q = (m_head + j) % D;
                    if (m_st[q]) begin
                        if (!m_ak[q]) blk = 1;
                        else if (m_addr[q] == m_addr[p]) begin hit = 1; hr = m_dk[q]; hd = m_data[q]; end
                    end
                end
                if (!blk && !(hit && !hr)) begin
                    v = 1; fwd = hit; idx = p; val = hit ? hd : m_addr[p];
                end
            end
        end
    endfunction

    task automatic tick();
        bit pv, pf, cok;
        int pi, tail, nc;
        logic [15:0] pval;
        #1;
        exp_pick(pv, pf, pi, pval);
        if (f_v) pv = 0;
        tail = (m_head + m_cnt) % D;
        cok  = c_v && m_cnt > 0 && complete(m_head);
        s_rdy = alloc_ready; s_tag = alloc_tag;
        s_mv = ld_mem_valid; s_mt = ld_mem_tag; s_ma = ld_mem_addr;
        s_fv = ld_fwd_valid; s_ft = ld_fwd_tag; s_fd = ld_fwd_data;
        s_sv = st_wr_valid;  s_sa = st_wr_addr; s_sd = st_wr_data;
        chk(s_rdy == (m_cnt < D), "R2 alloc_ready", s_rdy, m_cnt < D);
        if (m_cnt < D) chk(s_tag == 3'(tail), "R2 alloc_tag", s_tag, tail);
        chk(s_mv == (pv && !pf), "R7/R4/R3 ld_mem_valid", s_mv, pv && !pf);
        if (pv && !pf) chk({s_mt, s_ma} == {3'(pi), pval}, "R7 ld_mem tag/addr", {s_mt, s_ma}, {3'(pi), pval});
        chk(s_fv == (pv && pf), "R5/R6 ld_fwd_valid", s_fv, pv && pf);
        if (pv && pf) chk({s_ft, s_fd} == {3'(pi), pval}, "R5 ld_fwd tag/data", {s_ft, s_fd}, {3'(pi), pval});
        chk(s_sv == (cok && m_st[m_head]), "R8 st_wr_valid", s_sv, cok && m_st[m_head]);
        if (cok && m_st[m_head])
            chk({s_sa, s_sd} == {m_addr[m_head], m_data[m_head]}, "R8 st_wr addr/data",
                {s_sa, s_sd}, {m_addr[m_head], m_data[m_head]});
        // model update at the edge
        if (pv) m_dn[pi] = 1;
        if (g_v) begin m_ak[g_t] = 1; m_addr[g_t] = g_a; end
        if (d_v) begin m_dk[d_t] = 1; m_data[d_t] = d_d; end
        nc = m_cnt;
        if (f_v) nc = ((int'(f_t) - m_head + D) % D) + 1;
        else if (a_v && m_cnt < D) begin
            m_st[tail] = a_st; m_ak[tail] = 0; m_dk[tail] = 0; m_dn[tail] = 0; nc++;
        end
        if (cok) begin m_head = (m_head + 1) % D; nc--; end
        m_cnt = nc;
        @(negedge clk);
        a_v = 0; a_st = 0; g_v = 0; d_v = 0; c_v = 0; f_v = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        m_head = 0; m_cnt = 0;
        for (int i = 0; i < D; i++) begin m_st[i] = 0; m_ak[i] = 0; m_dk[i] = 0; m_dn[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();
        // R1 reset state
        tick();
        chk(s_rdy && s_tag == 0 && !s_mv && !s_fv && !s_sv, "R1 reset state",
            {s_rdy, s_tag, s_mv, s_fv, s_sv}, 7'b1000000);
        a_v = 1; a_st = 1; tick();                         // tag0 store
        chk(s_tag == 0, "R2 first tag", s_tag, 0);
        a_v = 1; a_st = 0; tick();                         // tag1 load
        a_v = 1; a_st = 1; tick();                         // tag2 store
        a_v = 1; a_st = 0; g_v = 1; g_t = 1; g_a = 5; tick(); // tag3 load, addr load1
        g_v = 1; g_t = 0; g_a = 5; d_v = 1; d_t = 0; d_d = 16'h1111; tick();
        chk(!s_mv && !s_fv, "R4 blocked by unknown store addr", {s_mv, s_fv}, 0);
        g_v = 1; g_t = 2; g_a = 5; tick();
        chk(s_fv && s_ft == 1 && s_fd == 16'h1111, "R5 forward from store0", {s_fv, s_ft, s_fd}, {1'b1, 3'd1, 16'h1111});
        g_v = 1; g_t = 3; g_a = 5; tick();
        d_v = 1; d_t = 2; d_d = 16'h2222; tick();
        chk(!s_mv && !s_fv, "R6 stall on matching store without data", {s_mv, s_fv}, 0);
        c_v = 1; a_v = 1; a_st = 0; tick();                // commit store0, alloc tag4
        chk(s_fv && s_ft == 3 && s_fd == 16'h2222, "R5 youngest match wins", {s_fv, s_ft, s_fd}, {1'b1, 3'd3, 16'h2222});
        chk(s_sv && s_sa == 5 && s_sd == 16'h1111, "R8 store write at commit", {s_sv, s_sa, s_sd}, {1'b1, 16'd5, 16'h1111});
        chk(s_tag == 4, "R9 alloc with commit", s_tag, 4);
        c_v = 1; g_v = 1; g_t = 4; g_a = 9; tick();        // commit load1
        chk(!s_sv, "R8 load retires without write", s_sv, 0);
        a_v = 1; a_st = 1; tick();                         // tag5 store
        chk(s_mv && s_mt == 4 && s_ma == 9, "R7 issue to cache", {s_mv, s_mt, s_ma}, {1'b1, 3'd4, 16'd9});
        f_v = 1; f_t = 3; a_v = 1; tick();                 // keep 2,3
        a_v = 1; a_st = 1; tick();
        chk(s_rdy && s_tag == 4, "R10 tag after flush", s_tag, 4);
        c_v = 1; tick();                                   // retire store2
        chk(s_sv && s_sd == 16'h2222, "R8 store2 write", s_sd, 16'h2222);
        c_v = 1; tick();                                   // retire load3
        c_v = 1; tick();                                   // head store4 incomplete
        chk(!s_sv, "R8 commit ignored on incomplete head", s_sv, 0);
        g_v = 1; g_t = 4; g_a = 7; d_v = 1; d_t = 4; d_d = 16'h4444; tick();
        c_v = 1; tick();
        chk(s_sv && s_sa == 7 && s_sd == 16'h4444, "R8 store4 retained then written", {s_sa, s_sd}, {16'd7, 16'h4444});
        for (int i = 0; i < D + 1; i++) begin a_v = 1; a_st = 0; tick(); end
        chk(!s_rdy, "R2 full queue not ready", s_rdy, 0);
        f_v = 1; f_t = 3'd5; tick();
        a_v = 1; tick();
        chk(s_tag == 6, "R10 flush to head", s_tag, 6);

        // random phase
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            if (m_cnt > 0 && $urandom % 24 == 0) begin
                f_v = 1; f_t = 3'((m_head + $urandom % m_cnt) % D);
                c_v = 1'($urandom % 2); a_v = 1'($urandom % 2);
            end else begin
                a_v = 1'($urandom % 2); a_st = 1'($urandom % 2);
                c_v = ($urandom % 3) != 0;
                if (m_cnt > 0) begin
                    int p = (m_head + $urandom % m_cnt) % D;
                    if (!m_ak[p]) begin g_v = 1; g_t = 3'(p); g_a = 16'($urandom % 4); end
                    p = (m_head + $urandom % m_cnt) % D;
                    if (m_st[p] && !m_dk[p]) begin d_v = 1; d_t = 3'(p); d_d = 16'($urandom); end
                end
            end
            tick();
        end
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule